// File: doc/BRIEF.md
# Serial-Loaded Octal DAC Register File

This block is the digital core of an eight-channel, 12-bit converter bank that keeps two ranks of storage per channel. A host shifts in 16-bit words, MSB first, on a serial data line. Each bit is taken on a falling edge of the serial clock, and the shifting is enabled by an active-low frame input. Each word carries a channel value, one device-address bit and a 3-bit channel select. The word is accepted only when its address bit equals a strap input. In that case it lands in the selected channel's input latch. A second rank of output latches drives eight parallel 12-bit codes toward the converters.

Two active-low strobes act on the output rank. The load strobe copies every input latch into its output latch at once. The clear strobe zeroes the output latches and leaves the input latches intact, so the previous codes can be restored by loading again. A serial output repeats the shifted bits sixteen clock edges later, which lets several devices share one daisy-chained data line.

All pins are sampled by the system clock through a synchronizer. Serial clock edges are found by edge detection inside the block, so the serial clock must run well below the system clock.

Top module: `dacrf_top`

## Requirements
- R1: While `frame_n` is low, each falling edge of `sclk` shifts `sdi` into a 16-bit register, and the first bit received ends up as the most significant bit.
- R2: In a received word, bits 15..4 are the channel value with its MSB first, bit 3 is the device-address bit, and bits 2..0 are the channel select.
- R3: A select value of n (0..7) addresses channel n. Channel n drives `dac_code[12*n+11 : 12*n]`.
- R4: On the sixteenth falling edge after `frame_n` goes low, the addressed input latch is written with the channel value, but only if bit 3 equals `addr_strap`.
- R5: A word whose bit 3 differs from `addr_strap` writes no input latch.
- R6: On the rising `sclk` edge that follows the k-th sampling edge of a frame (k ≥ 16), `sdo` shows bit number k−15 of that frame's stream. This holds for non-matching words too.
- R7: When `frame_n` stays low past sixteen bits, the later bits keep shifting toward `sdo`, but none of them loads a latch until `frame_n` has gone high and then low again.
- R8: While `load_n` is low and `clear_n` is high, all eight output latches take the contents of their input latches.
- R9: While `clear_n` is low, every output latch is zero. The input latches keep their values, so a later load restores the previous codes.
- R10: When `load_n` and `clear_n` are both low, the clear takes priority and the outputs stay zero until `clear_n` is released.
- R11: Reset zeroes both latch ranks, the bit counter and `sdo`. The bit counter also returns to zero whenever `frame_n` is high, so a frame cut off early has no effect on the next frame.
- R12: While both strobes are high, the output latches hold their values, even while input latches are being written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial and strobe pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| frame_n | input | 1 | Active-low frame enable for the shift register |
| sdi | input | 1 | Serial data in, MSB first |
| addr_strap | input | 1 | Device address compared with word bit 3 |
| load_n | input | 1 | Active-low strobe that copies the input rank to the output rank |
| clear_n | input | 1 | Active-low strobe that zeroes the output rank |
| sdo | output | 1 | Serial chain output, updated on rising `sclk` edges |
| dac_code | output | 96 | Eight 12-bit output-latch codes, channel 0 in the low bits |

## Verification
The bound checker watches the latch ranks on every cycle. It checks that a clear zeroes the outputs and leaves the input rank unchanged, that a load copies the input rank, that the outputs hold while both strobes are high, and that a non-matching capture writes nothing. It also checks that a matching capture writes the selected channel and that a frame yields at most one capture. The correct bit ordering, the sdo chain delay, the restart after an aborted frame and the channel decode are shown only by the bench scenarios. There, serial words are driven from the pins and the parallel codes and serial output are compared with a model held in the bench.

// File: rtl/dacrf_pkg.sv
package dacrf_pkg;
    localparam int unsigned CH_NUM_DEF = 8;
    localparam int unsigned VAL_W_DEF  = 12;
    localparam int unsigned SYNC_DEF   = 2;

    // serial word = value bits, one address bit, channel select bits
    function automatic int unsigned word_width(int unsigned val_w, int unsigned ch_num);
        return val_w + 1 + $clog2(ch_num);
    endfunction
endpackage

// File: rtl/dacrf_sync.sv
module dacrf_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= stage_d[i];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dacrf_shifter.sv
module dacrf_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              frame_n_s,
    input  logic              sdi_s,
    output logic              sdo,
    output logic              cap_valid,
    output logic [WORD_W-1:0] cap_word
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              sclk_prev;
        logic              sdo;
        logic              cap_valid;
        logic [WORD_W-1:0] cap_word;
    } sh_state_t;

    sh_state_t state_d, state_q;
    logic      fall_edge, rise_edge;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        state_d           = state_q;
        state_d.cap_valid = 1'b0;
        state_d.sclk_prev = sclk_s;
        fall_edge = state_q.sclk_prev & ~sclk_s;
        rise_edge = ~state_q.sclk_prev & sclk_s;
        shifted   = {state_q.shreg[WORD_W-2:0], sdi_s};

        if (frame_n_s) begin
            state_d.cnt = '0;
        end else if (fall_edge) begin
            state_d.shreg = shifted;
            if (state_q.cnt != CNT_FULL) begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
            if (state_q.cnt == CNT_LAST) begin
                state_d.cap_valid = 1'b1;
                state_d.cap_word  = shifted;
            end
        end

        if (rise_edge) begin
            state_d.sdo = state_q.shreg[WORD_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q           <= '0;
            state_q.sclk_prev <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign sdo       = state_q.sdo;
    assign cap_valid = state_q.cap_valid;
    assign cap_word  = state_q.cap_word;
endmodule

// File: rtl/dacrf_latches.sv
module dacrf_latches #(
    parameter int unsigned CH_NUM = 8,
    parameter int unsigned VAL_W  = 12,
    parameter int unsigned SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [VAL_W-1:0]        wr_val,
    input  logic                    load_n_s,
    input  logic                    clear_n_s,
    output logic [CH_NUM*VAL_W-1:0] in_flat,
    output logic [CH_NUM*VAL_W-1:0] dac_flat
);
    typedef struct packed {
        logic [CH_NUM-1:0][VAL_W-1:0] inr;
        logic [CH_NUM-1:0][VAL_W-1:0] dac;
    } lat_state_t;

    lat_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < int'(CH_NUM); i++) begin
            if (wr_en && (int'(wr_sel) == i)) begin
                state_d.inr[i] = wr_val;
            end
            if (!clear_n_s) begin
                state_d.dac[i] = '0;
            end else if (!load_n_s) begin
                state_d.dac[i] = state_q.inr[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar g = 0; g < int'(CH_NUM); g++) begin : g_chan_out
        assign in_flat[g*VAL_W +: VAL_W]  = state_q.inr[g];
        assign dac_flat[g*VAL_W +: VAL_W] = state_q.dac[g];
    end
endmodule

// File: rtl/dacrf_top.sv
module dacrf_top
    import dacrf_pkg::*;
#(
    parameter int unsigned CH_NUM      = CH_NUM_DEF,
    parameter int unsigned VAL_W       = VAL_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk,
    input  logic                    frame_n,
    input  logic                    sdi,
    input  logic                    addr_strap,
    input  logic                    load_n,
    input  logic                    clear_n,
    output logic                    sdo,
    output logic [CH_NUM*VAL_W-1:0] dac_code
);
    localparam int unsigned SEL_W  = $clog2(CH_NUM);
    localparam int unsigned WORD_W = word_width(VAL_W, CH_NUM);
    localparam int unsigned ADDR_BIT = SEL_W;

    // pin order in the synchronizer: sclk, frame_n, sdi, load_n, clear_n
    logic [4:0] pins_s;
    logic sclk_s, frame_n_s, sdi_s, load_n_s, clear_n_s;

    dacrf_sync #(
        .W       (5),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b11011)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sclk, frame_n, sdi, load_n, clear_n}),
        .sync_out (pins_s)
    );

    assign {sclk_s, frame_n_s, sdi_s, load_n_s, clear_n_s} = pins_s;

    logic              cap_valid;
    logic [WORD_W-1:0] cap_word;

    dacrf_shifter #(.WORD_W(WORD_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .frame_n_s (frame_n_s),
        .sdi_s     (sdi_s),
        .sdo       (sdo),
        .cap_valid (cap_valid),
        .cap_word  (cap_word)
    );

    logic             wr_en;
    logic [SEL_W-1:0] wr_sel;
    logic [VAL_W-1:0] wr_val;
    logic [CH_NUM*VAL_W-1:0] in_flat;

    assign wr_en  = cap_valid && (cap_word[ADDR_BIT] == addr_strap);
    assign wr_sel = cap_word[SEL_W-1:0];
    assign wr_val = cap_word[WORD_W-1 -: VAL_W];

    dacrf_latches #(
        .CH_NUM (CH_NUM),
        .VAL_W  (VAL_W),
        .SEL_W  (SEL_W)
    ) latches_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_val    (wr_val),
        .load_n_s  (load_n_s),
        .clear_n_s (clear_n_s),
        .in_flat   (in_flat),
        .dac_flat  (dac_code)
    );
endmodule

// File: rtl/dacrf_checker.sv
module dacrf_checker #(
    parameter int unsigned CH_NUM = 8,
    parameter int unsigned VAL_W  = 12,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned WORD_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_n_s,
    input logic                    load_n_s,
    input logic                    clear_n_s,
    input logic                    addr_strap,
    input logic                    cap_valid,
    input logic [WORD_W-1:0]       cap_word,
    input logic [CH_NUM*VAL_W-1:0] in_flat,
    input logic [CH_NUM*VAL_W-1:0] dac_code
);
    logic             seen_q;
    logic             pend_q;
    logic [SEL_W-1:0] exp_sel_q;
    logic [VAL_W-1:0] exp_val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            pend_q    <= 1'b0;
            exp_sel_q <= '0;
            exp_val_q <= '0;
        end else begin
            if (frame_n_s) seen_q <= 1'b0;
            else if (cap_valid) seen_q <= 1'b1;
            pend_q    <= cap_valid && (cap_word[SEL_W] == addr_strap);
            exp_sel_q <= cap_word[SEL_W-1:0];
            exp_val_q <= cap_word[WORD_W-1 -: VAL_W];
        end
    end

    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n_s |=> dac_code == '0);
    a_r9_clear_keeps_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_n_s && !cap_valid) |=> $stable(in_flat));
    a_r8_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n_s && !load_n_s) |=> dac_code == $past(in_flat));
    a_r12_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n_s && load_n_s) |=> $stable(dac_code));
    a_r5_mismatch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && (cap_word[SEL_W] != addr_strap)) |=> $stable(in_flat));
    a_r4_capture_written: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> in_flat[exp_sel_q*VAL_W +: VAL_W] == exp_val_q);
    a_r7_one_capture_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> !seen_q);
endmodule

bind dacrf_top dacrf_checker #(
    .CH_NUM (CH_NUM),
    .VAL_W  (VAL_W),
    .SEL_W  (SEL_W),
    .WORD_W (WORD_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n_s  (frame_n_s),
    .load_n_s   (load_n_s),
    .clear_n_s  (clear_n_s),
    .addr_strap (addr_strap),
    .cap_valid  (cap_valid),
    .cap_word   (cap_word),
    .in_flat    (in_flat),
    .dac_code   (dac_code)
);

// File: tb/dacrf_top_tb_top.sv
module dacrf_top_tb_top;
    localparam int CH = 8;
    localparam int VW = 12;
    localparam int T  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, frame_n = 1'b1, sdi = 1'b0, addr_strap = 1'b0;
    logic load_n = 1'b1, clear_n = 1'b1;
    logic sdo;
    logic [CH*VW-1:0] dac_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [VW-1:0] in_m  [CH];
    logic [VW-1:0] dac_m [CH];
    logic sdo_seen [64];

    always #2 clk = ~clk;

    dacrf_top dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_n(frame_n), .sdi(sdi),
        .addr_strap(addr_strap), .load_n(load_n), .clear_n(clear_n),
        .sdo(sdo), .dac_code(dac_code)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < CH; i++) begin
            check(32'(dac_code[i*VW +: VW]), 32'(dac_m[i]), tag);
        end
    endtask

    function automatic logic [15:0] mk_word(input logic [11:0] v, input logic a, input logic [2:0] s);
        return {v, a, s};
    endfunction

    // frame of n bits, MSB of the n-bit field first; model the one possible capture
    task automatic send_bits(input logic [63:0] bits, input int n);
        logic [15:0] w;
        frame_n = 1'b0;
        wait_cyc(T);
        for (int k = 0; k < n; k++) begin
            sdi = bits[n-1-k];
            wait_cyc(T);
            sclk = 1'b0;
            wait_cyc(T);
            sclk = 1'b1;
            wait_cyc(T);
            sdo_seen[k] = sdo;
        end
        wait_cyc(T);
        frame_n = 1'b1;
        wait_cyc(T);
        if (n >= 16) begin
            w = bits[n-1 -: 16];
            if (w[3] == addr_strap) in_m[w[2:0]] = w[15:4];
        end
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_cyc(6);
        load_n = 1'b1;
        wait_cyc(6);
        for (int i = 0; i < CH; i++) dac_m[i] = in_m[i];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] w1, w2;
        for (int i = 0; i < CH; i++) begin in_m[i] = '0; dac_m[i] = '0; end
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        // R11: reset state
        check_all("R11 reset outputs");
        check(32'(sdo), 0, "R11 reset sdo");

        // R1 R2 R3 R4: strap 0, every channel, distinct values
        addr_strap = 1'b0;
        for (int c = 0; c < CH; c++) begin
            send_bits(64'(mk_word(12'((c * 12'h2A5 + 12'h013) & 12'hFFF), 1'b0, 3'(c))), 16);
        end
        // R12: nothing visible before a load
        check_all("R12 hold before load");
        pulse_load();
        check_all("R3 R2 R8 channel decode strap0");

        // R4: strap 1, reverse order, inverted values
        addr_strap = 1'b1;
        for (int c = CH - 1; c >= 0; c--) begin
            send_bits(64'(mk_word(~12'((c * 12'h2A5 + 12'h013) & 12'hFFF), 1'b1, 3'(c))), 16);
        end
        pulse_load();
        check_all("R4 R1 capture strap1");

        // R5 R6 R7: mismatching word then a matching word in one long frame
        w1 = mk_word(12'hA5C, 1'b0, 3'd2);
        w2 = mk_word(12'h3C3, 1'b1, 3'd2);
        send_bits(64'({w1, w2}), 32);
        pulse_load();
        check(32'(dac_code[2*VW +: VW]), 32'(dac_m[2]), "R5 R7 mismatch then late word");
        for (int k = 15; k < 31; k++) begin
            check(32'(sdo_seen[k]), 32'(w1[15-(k-15)]), "R6 sdo chain of mismatched word");
        end
        check(32'(sdo_seen[31]), 32'(w2[15]), "R6 sdo second word first bit");

        // R7: matching first word captured, second one ignored
        w1 = mk_word(12'h5A1, 1'b1, 3'd4);
        w2 = mk_word(12'h0F0, 1'b1, 3'd5);
        send_bits(64'({w1, w2}), 32);
        pulse_load();
        check(32'(dac_code[4*VW +: VW]), 32'h5A1, "R7 first word captured");
        check(32'(dac_code[5*VW +: VW]), 32'(dac_m[5]), "R7 second word ignored");

        // R11: aborted frame then a full one
        send_bits(64'(10'h3FF), 10);
        send_bits(64'(mk_word(12'h7E2, 1'b1, 3'd6)), 16);
        pulse_load();
        check_all("R11 aborted frame restart");

        // R9: clear zeroes outputs, keeps inputs
        clear_n = 1'b0;
        wait_cyc(6);
        for (int i = 0; i < CH; i++) check(32'(dac_code[i*VW +: VW]), 0, "R9 clear zero");
        clear_n = 1'b1;
        wait_cyc(6);
        for (int i = 0; i < CH; i++) check(32'(dac_code[i*VW +: VW]), 0, "R12 hold after clear");
        pulse_load();
        check_all("R9 restore after clear");

        // R10: clear beats load
        clear_n = 1'b0;
        load_n  = 1'b0;
        wait_cyc(6);
        for (int i = 0; i < CH; i++) check(32'(dac_code[i*VW +: VW]), 0, "R10 clear priority");
        clear_n = 1'b1;
        wait_cyc(6);
        check_all("R10 load after clear release");
        load_n = 1'b1;
        wait_cyc(6);

        // R3 R8 boundary codes per channel, load after each write
        for (int c = 0; c < CH; c++) begin
            send_bits(64'(mk_word((c % 2 == 0) ? 12'hFFF : 12'h000, 1'b1, 3'(c))), 16);
            pulse_load();
            check_all("R3 R8 boundary codes");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule